// File: doc/BRIEF.md
# Port Handshake Pin Controller

This block decides what drives the four upper pins of an 8-bit microcontroller output port. After reset each pin shows the bit the core last wrote to its latch. Two single-cycle commands from the core switch pairs of pins into handshake duty. The first command turns pin 4 into a buffer-full signal for the host's output buffer and pin 5 into a ready signal for its input buffer. The second command turns pin 6 into a DMA request and pin 7 into the acknowledge input from the DMA controller. The core keeps writing the same latch bits, and in the handshake modes those writes act as enables or as request triggers.

Two state machines make up the controller. The mode machine has four states: `MODE_PLAIN`, `MODE_FLAGS`, `MODE_DMA` and `MODE_BOTH`. Its transitions are PLAIN→FLAGS on the flags command, PLAIN→DMA on the DMA command, PLAIN→BOTH when both commands arrive in one cycle, FLAGS→BOTH on the DMA command, and DMA→BOTH on the flags command. Only reset leaves a state. The request machine has two states, `REQ_IDLE` and `REQ_PEND`. It moves IDLE→PEND on a request trigger in DMA mode when no clear is present, and PEND→IDLE on any clear condition. Latch bit positions are fixed: `latch_wdata[0]` is pin 4, `[1]` is pin 5, `[2]` is pin 6 and `[3]` is pin 7. On `pin_out` the same order applies.

Top module: `hs_pin_ctrl`

## Requirements
- R1: While and after reset, the latch holds 4'hF, both modes are off, `drq` is 0, `dack_sel` is 0 and `pin_out` is 4'hF.
- R2: When no handshake mode applies to a pin, `pin_out` shows the latch bit written by the last `latch_we` cycle, from the clock edge that captures the write onward.
- R3: In flags mode, `pin_out[0]` equals latch bit 0 AND `obf`. A latch value of 0 forces the pin low.
- R4: In flags mode, `pin_out[1]` equals latch bit 1 AND NOT `ibf`. A latch value of 0 forces the pin low.
- R5: In DMA mode, a `latch_we` cycle with `latch_wdata[2]`=1 sets `drq` at the next edge. `pin_out[2]` equals `drq`. A write with bit 2 = 0 does not clear `drq`.
- R6: `drq` clears at the next edge when `dack_sel` is 1 together with `host_rd` or `host_wr`. A host strobe without `dack_sel` leaves `drq` unchanged.
- R7: Asserting `cmd_en_dma` again while in DMA mode clears `drq`.
- R8: If a set and a clear of `drq` happen in the same cycle, `drq` ends up 0.
- R9: In DMA mode, `pin_out[3]` is held at 1 (released) and `dack_sel` equals NOT `pin7_in` (active-low acknowledge). Outside DMA mode, `dack_sel` is 0 and `pin7_in` is ignored.
- R10: Once set, each mode stays set until reset. The flags command does not change pins 6 and 7, and the DMA command does not change pins 4 and 5.
- R11: A latch write with bit 2 = 1 made before DMA mode is entered does not set `drq`, either then or later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| latch_we | input | 1 | Core write strobe for the upper latch bits |
| latch_wdata | input | 4 | Latch data, bit 0 = pin 4 ... bit 3 = pin 7 |
| cmd_en_flags | input | 1 | One-cycle enable-flags command |
| cmd_en_dma | input | 1 | One-cycle enable-DMA command |
| obf | input | 1 | Output-buffer-full status bit |
| ibf | input | 1 | Input-buffer-full status bit |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| pin7_in | input | 1 | Level sampled from pin 7 (acknowledge, active low) |
| pin_out | output | 4 | Values driven onto pins 4..7 |
| drq | output | 1 | DMA request |
| dack_sel | output | 1 | Buffer select from an active acknowledge |

## Verification
A wrong mode state appears on the pins in the cycle after the bad edge. Pin 4 or 5 stops tracking its status bit, or pin 6 or 7 shows the latch instead of the request or the released level. `dack_sel` also goes wrong as soon as `pin7_in` falls. A request state that is wrong, for example a missed clear, a clear that loses to a set, or a set made outside DMA mode, shows on `drq` and on pin 6 one edge after the triggering cycle. The vectors drive each set and clear pair together in a single cycle to expose a wrong priority.

// File: rtl/hs_pin_pkg.sv
package hs_pin_pkg;

    // Position of each handshake role within the upper latch nibble
    localparam int PIN_OBF = 0;
    localparam int PIN_IBF = 1;
    localparam int PIN_DRQ = 2;
    localparam int PIN_ACK = 3;
    localparam int ROLE_COUNT = 4;

    typedef enum logic [1:0] {
        MODE_PLAIN = 2'd0,
        MODE_FLAGS = 2'd1,
        MODE_DMA   = 2'd2,
        MODE_BOTH  = 2'd3
    } mode_e;

    typedef enum logic {
        REQ_IDLE = 1'b0,
        REQ_PEND = 1'b1
    } req_e;

    typedef enum logic [2:0] {
        ROLE_OBF,
        ROLE_IBF,
        ROLE_DRQ,
        ROLE_ACK,
        ROLE_NONE
    } role_e;

    function automatic role_e pin_role(input int idx);
        case (idx)
            PIN_OBF: pin_role = ROLE_OBF;
            PIN_IBF: pin_role = ROLE_IBF;
            PIN_DRQ: pin_role = ROLE_DRQ;
            PIN_ACK: pin_role = ROLE_ACK;
            default: pin_role = ROLE_NONE;
        endcase
    endfunction

endpackage

// File: rtl/hs_mode_fsm.sv
module hs_mode_fsm
    import hs_pin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_flags,
    input  logic cmd_dma,
    output logic flags_on,
    output logic dma_on
);

    mode_e state_q;
    mode_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MODE_PLAIN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_PLAIN: begin
                if (cmd_flags && cmd_dma) begin
                    state_d = MODE_BOTH;
                end else if (cmd_flags) begin
                    state_d = MODE_FLAGS;
                end else if (cmd_dma) begin
                    state_d = MODE_DMA;
                end
            end
            MODE_FLAGS: begin
                if (cmd_dma) begin
                    state_d = MODE_BOTH;
                end
            end
            MODE_DMA: begin
                if (cmd_flags) begin
                    state_d = MODE_BOTH;
                end
            end
            MODE_BOTH: begin
                state_d = MODE_BOTH;
            end
            default: begin
                state_d = MODE_PLAIN;
            end
        endcase
    end

    always_comb begin
        flags_on = 1'b0;
        dma_on   = 1'b0;
        unique case (state_q)
            MODE_PLAIN: begin
                flags_on = 1'b0;
                dma_on   = 1'b0;
            end
            MODE_FLAGS: begin
                flags_on = 1'b1;
            end
            MODE_DMA: begin
                dma_on = 1'b1;
            end
            MODE_BOTH: begin
                flags_on = 1'b1;
                dma_on   = 1'b1;
            end
            default: begin
                flags_on = 1'b0;
                dma_on   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/hs_drq_fsm.sv
module hs_drq_fsm
    import hs_pin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dma_on,
    input  logic set_req,
    input  logic clr_req,
    output logic drq
);

    req_e state_q;
    req_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= REQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // A clear always takes priority over a trigger in the same cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE: begin
                if (dma_on && set_req && !clr_req) begin
                    state_d = REQ_PEND;
                end
            end
            REQ_PEND: begin
                if (clr_req) begin
                    state_d = REQ_IDLE;
                end
            end
            default: begin
                state_d = REQ_IDLE;
            end
        endcase
    end

    always_comb begin
        unique case (state_q)
            REQ_IDLE: drq = 1'b0;
            REQ_PEND: drq = 1'b1;
            default:  drq = 1'b0;
        endcase
    end

endmodule

// File: rtl/hs_pin_mux.sv
module hs_pin_mux
    import hs_pin_pkg::*;
#(
    parameter int UP_W = ROLE_COUNT
) (
    input  logic [UP_W-1:0] latch_q,
    input  logic            flags_on,
    input  logic            dma_on,
    input  logic            obf,
    input  logic            ibf,
    input  logic            drq,
    output logic [UP_W-1:0] pin_out
);

    for (genvar i = 0; i < UP_W; i++) begin : g_pin
        localparam role_e ROLE = pin_role(i);
        if (ROLE == ROLE_OBF) begin : g_obf
            assign pin_out[i] = flags_on ? (latch_q[i] & obf) : latch_q[i];
        end else if (ROLE == ROLE_IBF) begin : g_ibf
            assign pin_out[i] = flags_on ? (latch_q[i] & ~ibf) : latch_q[i];
        end else if (ROLE == ROLE_DRQ) begin : g_drq
            assign pin_out[i] = dma_on ? drq : latch_q[i];
        end else if (ROLE == ROLE_ACK) begin : g_ack
            assign pin_out[i] = dma_on ? 1'b1 : latch_q[i];
        end else begin : g_plain
            assign pin_out[i] = latch_q[i];
        end
    end

endmodule

// File: rtl/hs_pin_ctrl.sv
module hs_pin_ctrl
    import hs_pin_pkg::*;
#(
    parameter int               UP_W      = ROLE_COUNT,
    parameter logic [UP_W-1:0]  LATCH_RST = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            latch_we,
    input  logic [UP_W-1:0] latch_wdata,
    input  logic            cmd_en_flags,
    input  logic            cmd_en_dma,
    input  logic            obf,
    input  logic            ibf,
    input  logic            host_rd,
    input  logic            host_wr,
    input  logic            pin7_in,
    output logic [UP_W-1:0] pin_out,
    output logic            drq,
    output logic            dack_sel
);

    logic [UP_W-1:0] latch_q;
    logic            flags_on;
    logic            dma_on;
    logic            set_req;
    logic            clr_req;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= LATCH_RST;
        end else if (latch_we) begin
            latch_q <= latch_wdata;
        end
    end

    hs_mode_fsm u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_flags (cmd_en_flags),
        .cmd_dma   (cmd_en_dma),
        .flags_on  (flags_on),
        .dma_on    (dma_on)
    );

    // Acknowledge pin is active low and only meaningful in DMA mode
    assign dack_sel = dma_on & ~pin7_in;
    assign set_req  = latch_we & latch_wdata[PIN_DRQ];
    assign clr_req  = cmd_en_dma | (dack_sel & (host_rd | host_wr));

    hs_drq_fsm u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .dma_on  (dma_on),
        .set_req (set_req),
        .clr_req (clr_req),
        .drq     (drq)
    );

    hs_pin_mux #(.UP_W(UP_W)) u_mux (
        .latch_q  (latch_q),
        .flags_on (flags_on),
        .dma_on   (dma_on),
        .obf      (obf),
        .ibf      (ibf),
        .drq      (drq),
        .pin_out  (pin_out)
    );

endmodule

// File: rtl/hs_pin_ctrl_chk.sv
module hs_pin_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       latch_we,
    input logic [3:0] latch_wdata,
    input logic       cmd_en_dma,
    input logic       obf,
    input logic       ibf,
    input logic       host_rd,
    input logic       host_wr,
    input logic [3:0] pin_out,
    input logic       drq,
    input logic       dack_sel,
    input logic       flags_on,
    input logic       dma_on
);

    AST_DRQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_on && latch_we && latch_wdata[2] && !cmd_en_dma && !(dack_sel && (host_rd || host_wr))) |=> drq); // R5

    AST_DRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (drq && !cmd_en_dma && !(dack_sel && (host_rd || host_wr))) |=> drq); // R5

    AST_DRQ_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (dack_sel && (host_rd || host_wr)) |=> !drq); // R6

    AST_DRQ_CMD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_en_dma |=> !drq); // R7

    AST_DRQ_ONLY_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        drq |-> dma_on); // R11

    AST_OBF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_on && !obf) |-> !pin_out[0]); // R3

    AST_IBF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_on && ibf) |-> !pin_out[1]); // R4

    AST_ACK_PIN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        dma_on |-> pin_out[3]); // R9

    AST_NO_ACK_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_on |-> !dack_sel); // R9

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flags_on |=> flags_on); // R10

    AST_DMA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        dma_on |=> dma_on); // R10

endmodule

bind hs_pin_ctrl hs_pin_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .latch_we    (latch_we),
    .latch_wdata (latch_wdata),
    .cmd_en_dma  (cmd_en_dma),
    .obf         (obf),
    .ibf         (ibf),
    .host_rd     (host_rd),
    .host_wr     (host_wr),
    .pin_out     (pin_out),
    .drq         (drq),
    .dack_sel    (dack_sel),
    .flags_on    (flags_on),
    .dma_on      (dma_on)
);

// File: tb/sim_hs_pin_ctrl.sv
module sim_hs_pin_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       latch_we = 1'b0;
    logic [3:0] latch_wdata = 4'h0;
    logic       cmd_en_flags = 1'b0;
    logic       cmd_en_dma = 1'b0;
    logic       obf = 1'b0;
    logic       ibf = 1'b0;
    logic       host_rd = 1'b0;
    logic       host_wr = 1'b0;
    logic       pin7_in = 1'b1;
    logic [3:0] pin_out;
    logic       drq;
    logic       dack_sel;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hs_pin_ctrl u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .latch_we     (latch_we),
        .latch_wdata  (latch_wdata),
        .cmd_en_flags (cmd_en_flags),
        .cmd_en_dma   (cmd_en_dma),
        .obf          (obf),
        .ibf          (ibf),
        .host_rd      (host_rd),
        .host_wr      (host_wr),
        .pin7_in      (pin7_in),
        .pin_out      (pin_out),
        .drq          (drq),
        .dack_sel     (dack_sel)
    );

    // Vector: {we, wdata[3:0], ef, ed, obf, ibf, rd, wr, p7, exp_pins[3:0], exp_drq, exp_dack, req[3:0]}
    localparam int NV = 24;
    localparam logic [21:0] VEC [NV] = '{
        {1'b0, 4'h0, 7'b0000001, 4'hF, 2'b00, 4'd1},  // R1 idle after reset
        {1'b1, 4'h5, 7'b0000001, 4'h5, 2'b00, 4'd2},  // R2 plain write
        {1'b1, 4'hA, 7'b0000001, 4'hA, 2'b00, 4'd2},  // R2 plain write
        {1'b0, 4'h0, 7'b0000110, 4'hA, 2'b00, 4'd9},  // R9 ack ignored outside DMA
        {1'b1, 4'h4, 7'b0000001, 4'h4, 2'b00, 4'd11}, // R11 trigger before DMA mode
        {1'b1, 4'h3, 7'b1000001, 4'h2, 2'b00, 4'd3},  // R3 flags on, obf low
        {1'b0, 4'h0, 7'b0010001, 4'h3, 2'b00, 4'd3},  // R3 obf high
        {1'b0, 4'h0, 7'b0011001, 4'h1, 2'b00, 4'd4},  // R4 ibf high
        {1'b0, 4'h0, 7'b0001001, 4'h0, 2'b00, 4'd4},  // R4
        {1'b1, 4'hC, 7'b0010001, 4'hC, 2'b00, 4'd10}, // R10 pins 6/7 still plain
        {1'b0, 4'h0, 7'b0110001, 4'h8, 2'b00, 4'd11}, // R11 DMA entered, no stale request
        {1'b1, 4'h7, 7'b0010001, 4'hF, 2'b10, 4'd5},  // R5 request set
        {1'b1, 4'h3, 7'b0010001, 4'hF, 2'b10, 4'd5},  // R5 zero write keeps request
        {1'b0, 4'h0, 7'b0010101, 4'hF, 2'b10, 4'd6},  // R6 read without ack
        {1'b0, 4'h0, 7'b0010000, 4'hF, 2'b11, 4'd9},  // R9 ack low selects buffer
        {1'b0, 4'h0, 7'b0010100, 4'hB, 2'b01, 4'd6},  // R6 ack + read clears
        {1'b1, 4'h4, 7'b0010001, 4'hC, 2'b10, 4'd5},  // R5 set again
        {1'b0, 4'h0, 7'b0010010, 4'h8, 2'b01, 4'd6},  // R6 ack + write clears
        {1'b1, 4'h4, 7'b0010001, 4'hC, 2'b10, 4'd5},  // R5 set again
        {1'b0, 4'h0, 7'b0110001, 4'h8, 2'b00, 4'd7},  // R7 re-issued command clears
        {1'b1, 4'h4, 7'b0010001, 4'hC, 2'b10, 4'd10}, // R10 DMA still on
        {1'b1, 4'h4, 7'b0110001, 4'h8, 2'b00, 4'd8},  // R8 set + command clear
        {1'b1, 4'h4, 7'b0010010, 4'h8, 2'b01, 4'd8},  // R8 set + ack clear
        {1'b0, 4'h0, 7'b1000001, 4'h8, 2'b00, 4'd10}  // R10 repeat flags command
    };

    task automatic check(input logic [3:0] ep, input logic ed, input logic ea, input int req);
        checks++;
        if (pin_out !== ep || drq !== ed || dack_sel !== ea) begin
            fails++;
            $display("FAIL R%0d: pins=%h drq=%b dack=%b expected pins=%h drq=%b dack=%b",
                     req, pin_out, drq, dack_sel, ep, ed, ea);
        end
    endtask

    task automatic apply(input logic [21:0] v);
        {latch_we, latch_wdata, cmd_en_flags, cmd_en_dma, obf, ibf, host_rd, host_wr, pin7_in} = v[21:10];
        @(posedge clk);
        #5;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #5;
        check(4'hF, 1'b0, 1'b0, 1); // R1 during reset
        rst_n = 1'b1;
        @(posedge clk);
        #5;
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            check(VEC[i][9:6], VEC[i][5], VEC[i][4], int'(VEC[i][3:0]));
        end
        // R1: reset mid-run returns to plain mode with ack ignored
        {latch_we, cmd_en_flags, cmd_en_dma, host_rd, host_wr} = '0;
        pin7_in = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        #5;
        check(4'hF, 1'b0, 1'b0, 1);
        rst_n = 1'b1;
        @(posedge clk);
        #5;
        check(4'hF, 1'b0, 1'b0, 1);
        // R10: DMA alone leaves pins 4/5 plain
        pin7_in = 1'b1;
        apply({1'b1, 4'h3, 7'b0101001, 4'h0, 2'b00, 4'd10});
        check(4'hB, 1'b0, 1'b0, 10);
        // R9: pin 7 latch value ignored in DMA mode
        apply({1'b1, 4'h0, 7'b0000001, 4'h0, 2'b00, 4'd9});
        check(4'h8, 1'b0, 1'b0, 9);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (2000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule